// File: doc/BRIEF.md
# Flash Status Word Generator

This block forms the byte that a flash device places on its data bus whenever a read happens while an embedded program or erase is running, while an error from one of those operations is being held, or while an erase is suspended and the read falls in a block scheduled for erase. It also drives a select that tells the bus multiplexer whether the byte shown should be this status word or the ordinary array data. The array itself lives elsewhere.

The operation sequencer reports its phase on `op_state` every cycle. A one-cycle `fail_evt` reports a failed operation, and a one-cycle `reset_cmd` reports the command that clears an error. The block keeps a small state machine with six states: IDLE, PROG, EWIN (erase with the block-selection window still open), ERASE, SUSP and ERR. It also keeps two toggle flip-flops that flip on qualified read strobes. One toggle answers reads at any address. The other answers only reads that fall in erasing blocks, or in failed blocks after an erase error.

State transitions, evaluated at each rising clock edge:
- Any state except ERR follows the decoded `op_state`.
- PROG, EWIN or ERASE go to ERR on `fail_evt`, which takes priority over `op_state`.
- ERR goes to IDLE on `reset_cmd` and otherwise stays in ERR.
- START is the name for a move from IDLE into PROG, EWIN or ERASE, or from SUSP into PROG. START clears both toggles.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the state is IDLE. In IDLE, `status` is 00h and `show_status` is 0.
- R2: Bit 7 of the status word has these values:
  - In PROG, and after a program error, it is the inverse of `pend_d7`.
  - In EWIN, ERASE and after an erase error, it is 0.
  - In SUSP on an erasing-block read, it is 1.
- R3: Bit 6 shows the any-address toggle. This toggle flips at each clock edge that has `rd_stb` high while the state is PROG, EWIN, ERASE or ERR.
- R4: In SUSP the any-address toggle does not flip, even when `rd_stb` is high.
- R5: A `fail_evt` in PROG, EWIN or ERASE moves the state to ERR. In ERR:
  - bit 5 reads 1 and `show_status` is 1 at every address;
  - the state ignores `op_state` until `reset_cmd` returns it to IDLE.
- R6: Bit 3 reads 0 in EWIN and in SUSP. It reads 1 in ERASE and after an erase error.
- R7: Bit 2 shows the selective toggle. In EWIN, ERASE and SUSP this toggle flips on `rd_stb` only while `addr_in_erase` is 1. In PROG and after a program error, bit 2 reads 0.
- R8: After an erase error, the selective toggle flips on `rd_stb` only while `blk_failed` is 1.
- R9: In SUSP, a read with `addr_in_erase` at 0 gives `show_status` 0 and `status` 00h.
- R10: Bits 4, 1 and 0 of `status` always read 0.
- R11: A START clears both toggles to 0, so the first status read of a new operation shows 0 on bits 6 and 2.
- R12: `op_state` encodes the phase as follows, and `reset_cmd` outside ERR has no effect:
  - 0: IDLE
  - 1: PROG
  - 2: EWIN
  - 3: ERASE
  - 4: SUSP
  - 5 to 7: IDLE

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Operation phase code from the sequencer |
| fail_evt | input | 1 | One-cycle pulse: the running operation failed |
| reset_cmd | input | 1 | One-cycle pulse: error-clearing command seen |
| rd_stb | input | 1 | One-cycle pulse per bus read |
| addr_in_erase | input | 1 | Read address lies in a block marked for erase |
| blk_failed | input | 1 | Read address lies in a block that failed to erase |
| pend_d7 | input | 1 | Bit 7 of the byte being programmed |
| status | output | 8 | Status word (combinational from state and inputs) |
| show_status | output | 1 | 1: bus shows `status`; 0: bus shows array data |

## Verification
Some properties hold on every cycle, and the checker tests those each cycle:
- the error flag stays set until the clearing command arrives;
- the undefined bits stay at zero;
- bit 3 is high during the erase itself;
- reads of non-erasing blocks during suspend go to the array;
- the any-address toggle holds still through suspend and flips on each read during a program.

Other behaviour only shows up over the bench's directed and random sequences:
- the toggles clear at each operation start, including a program launched from suspend;
- the selective toggle follows the failed-block flag after an erase error;
- the polling bit takes the correct value in each phase.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int OP_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_EWIN  = 3'd2,
        ST_ERASE = 3'd3,
        ST_SUSP  = 3'd4,
        ST_ERR   = 3'd5
    } fsg_state_e;

    localparam logic [OP_W-1:0] OPC_IDLE  = 3'd0;
    localparam logic [OP_W-1:0] OPC_PROG  = 3'd1;
    localparam logic [OP_W-1:0] OPC_EWIN  = 3'd2;
    localparam logic [OP_W-1:0] OPC_ERASE = 3'd3;
    localparam logic [OP_W-1:0] OPC_SUSP  = 3'd4;

    // Bit positions inside the status word
    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_FAIL  = 5;
    localparam int POS_TIMER = 3;
    localparam int POS_ALT   = 2;

    localparam int NUM_TOG = 2;
    localparam int TOG_ANY = 0;
    localparam int TOG_SEL = 1;
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_state,
    input  logic            fail_evt,
    input  logic            reset_cmd,
    output fsg_state_e      st,
    output logic            err_erase,
    output logic            start
);
    fsg_state_e st_q;
    fsg_state_e st_nx;
    fsg_state_e op_dec;
    logic       err_erase_q;

    always_comb begin
        unique case (op_state)
            OPC_PROG:  op_dec = ST_PROG;
            OPC_EWIN:  op_dec = ST_EWIN;
            OPC_ERASE: op_dec = ST_ERASE;
            OPC_SUSP:  op_dec = ST_SUSP;
            default:   op_dec = ST_IDLE;
        endcase
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_ERR: begin
                if (reset_cmd) st_nx = ST_IDLE;
            end
            ST_PROG, ST_EWIN, ST_ERASE: begin
                if (fail_evt) st_nx = ST_ERR;
                else          st_nx = op_dec;
            end
            default: st_nx = op_dec;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            err_erase_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (st_q != ST_ERR && st_nx == ST_ERR)
                err_erase_q <= (st_q != ST_PROG);
        end
    end

    always_comb begin
        st        = st_q;
        err_erase = err_erase_q;
        start     = ((st_q == ST_IDLE) &&
                     (st_nx == ST_PROG || st_nx == ST_EWIN || st_nx == ST_ERASE)) ||
                    ((st_q == ST_SUSP) && (st_nx == ST_PROG));
    end
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_r <= 1'b0;
        else if (clr) q_r <= 1'b0;
        else if (adv) q_r <= ~q_r;
    end

    assign q = q_r;
endmodule

// File: rtl/fsg_pack.sv
module fsg_pack
    import fsg_pkg::*;
#(
    parameter int DW = 8
) (
    input  fsg_state_e    st,
    input  logic          err_erase,
    input  logic          tog_any,
    input  logic          tog_sel,
    input  logic          pend_d7,
    input  logic          addr_in_erase,
    output logic [DW-1:0] status,
    output logic          show_status
);
    always_comb begin
        status      = '0;
        show_status = 1'b1;
        unique case (st)
            ST_IDLE: begin
                show_status = 1'b0;
            end
            ST_PROG: begin
                status[POS_POLL] = ~pend_d7;
                status[POS_TOG]  = tog_any;
            end
            ST_EWIN: begin
                status[POS_TOG] = tog_any;
                status[POS_ALT] = tog_sel;
            end
            ST_ERASE: begin
                status[POS_TOG]   = tog_any;
                status[POS_TIMER] = 1'b1;
                status[POS_ALT]   = tog_sel;
            end
            ST_SUSP: begin
                show_status = addr_in_erase;
                if (addr_in_erase) begin
                    status[POS_POLL] = 1'b1;
                    status[POS_TOG]  = tog_any;
                    status[POS_ALT]  = tog_sel;
                end
            end
            ST_ERR: begin
                status[POS_TOG]  = tog_any;
                status[POS_FAIL] = 1'b1;
                if (err_erase) begin
                    status[POS_TIMER] = 1'b1;
                    status[POS_ALT]   = tog_sel;
                end else begin
                    status[POS_POLL] = ~pend_d7;
                end
            end
            default: begin
                show_status = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_state,
    input  logic            fail_evt,
    input  logic            reset_cmd,
    input  logic            rd_stb,
    input  logic            addr_in_erase,
    input  logic            blk_failed,
    input  logic            pend_d7,
    output logic [DW-1:0]   status,
    output logic            show_status
);
    fsg_state_e         st_q;
    logic               err_erase;
    logic               op_start;
    logic [NUM_TOG-1:0] tog_adv;
    logic [NUM_TOG-1:0] tog_q;
    logic               busy_any;
    logic               sel_qual;

    fsg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_state  (op_state),
        .fail_evt  (fail_evt),
        .reset_cmd (reset_cmd),
        .st        (st_q),
        .err_erase (err_erase),
        .start     (op_start)
    );

    always_comb begin
        busy_any = (st_q == ST_PROG) || (st_q == ST_EWIN) ||
                   (st_q == ST_ERASE) || (st_q == ST_ERR);
        sel_qual = ((st_q == ST_EWIN || st_q == ST_ERASE || st_q == ST_SUSP) && addr_in_erase) ||
                   ((st_q == ST_ERR) && err_erase && blk_failed);
        tog_adv[TOG_ANY] = rd_stb && busy_any;
        tog_adv[TOG_SEL] = rd_stb && sel_qual;
    end

    for (genvar gi = 0; gi < NUM_TOG; gi++) begin : g_tog
        fsg_toggle u_tog (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (op_start),
            .adv   (tog_adv[gi]),
            .q     (tog_q[gi])
        );
    end

    fsg_pack #(.DW(DW)) u_pack (
        .st            (st_q),
        .err_erase     (err_erase),
        .tog_any       (tog_q[TOG_ANY]),
        .tog_sel       (tog_q[TOG_SEL]),
        .pend_d7       (pend_d7),
        .addr_in_erase (addr_in_erase),
        .status        (status),
        .show_status   (show_status)
    );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import fsg_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_state,
    input logic            fail_evt,
    input logic            reset_cmd,
    input logic            rd_stb,
    input logic            addr_in_erase,
    input logic [DW-1:0]   status,
    input logic            show_status,
    input fsg_state_e      st,
    input logic            tog_any
);
    // R5: error flag persists until clearing command
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[POS_FAIL] && !reset_cmd) |=> (status[POS_FAIL] && show_status));

    // R10: undefined bits held low
    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] == 1'b0 && status[1] == 1'b0 && status[0] == 1'b0));

    // R6: timer bit high while erasing
    assert_timer_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |-> status[POS_TIMER]);

    // R9: suspended read outside erasing blocks shows array data
    assert_susp_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && !addr_in_erase) |-> !show_status);

    // R4: any-address toggle frozen through suspend
    assert_susp_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && op_state == OPC_SUSP) |=> $stable(tog_any));

    // R3: any-address toggle flips on each read during program
    assert_prog_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && rd_stb && op_state == OPC_PROG && !fail_evt)
        |=> (status[POS_TOG] != $past(status[POS_TOG])));
endmodule

bind flash_status_gen fsg_checker #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_state      (op_state),
    .fail_evt      (fail_evt),
    .reset_cmd     (reset_cmd),
    .rd_stb        (rd_stb),
    .addr_in_erase (addr_in_erase),
    .status        (status),
    .show_status   (show_status),
    .st            (st_q),
    .tog_any       (tog_q[0])
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_state = 3'd0;
    logic       fail_evt = 1'b0, reset_cmd = 1'b0, rd_stb = 1'b0;
    logic       addr_in_erase = 1'b0, blk_failed = 1'b0, pend_d7 = 1'b0;
    logic [7:0] status;
    logic       show_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // model: 0 idle,1 prog,2 ewin,3 erase,4 susp,5 err
    int m_st = 0;
    bit m_ee = 0, m_t6 = 0, m_t2 = 0;

    always #4 clk = ~clk;

    flash_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .op_state(op_state), .fail_evt(fail_evt),
        .reset_cmd(reset_cmd), .rd_stb(rd_stb), .addr_in_erase(addr_in_erase),
        .blk_failed(blk_failed), .pend_d7(pend_d7),
        .status(status), .show_status(show_status)
    );

    function automatic int dec_op(logic [2:0] c);
        return (c <= 3'd4) ? int'(c) : 0;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        case (m_st)
            1: begin s[7] = ~pend_d7; s[6] = m_t6; end
            2: begin s[6] = m_t6; s[2] = m_t2; end
            3: begin s[6] = m_t6; s[3] = 1'b1; s[2] = m_t2; end
            4: if (addr_in_erase) begin s[7] = 1'b1; s[6] = m_t6; s[2] = m_t2; end
            5: begin
                s[6] = m_t6; s[5] = 1'b1;
                if (m_ee) begin s[3] = 1'b1; s[2] = m_t2; end
                else s[7] = ~pend_d7;
            end
            default: s = 8'h00;
        endcase
        return s;
    endfunction

    function automatic bit exp_show();
        if (m_st == 0) return 1'b0;
        if (m_st == 4) return addr_in_erase;
        return 1'b1;
    endfunction

    function automatic string st_tag();
        case (m_st)
            1: return "R2";
            2: return "R6";
            3: return "R7";
            4: return "R4";
            5: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic model_edge();
        int  nx;
        bit  busy, selq, strt;
        if (m_st == 5) nx = reset_cmd ? 0 : 5;
        else if (fail_evt && (m_st >= 1 && m_st <= 3)) nx = 5;
        else nx = dec_op(op_state);
        busy = (m_st >= 1 && m_st <= 3) || m_st == 5;
        selq = ((m_st >= 2 && m_st <= 4) && addr_in_erase) ||
               (m_st == 5 && m_ee && blk_failed);
        strt = (m_st == 0 && nx >= 1 && nx <= 3) || (m_st == 4 && nx == 1);
        if (strt) begin m_t6 = 0; m_t2 = 0; end
        else begin
            if (rd_stb && busy) m_t6 = ~m_t6;
            if (rd_stb && selq) m_t2 = ~m_t2;
        end
        if (m_st != 5 && nx == 5) m_ee = (m_st != 1);
        m_st = nx;
    endtask

    task automatic check(string tag);
        logic [7:0] es = exp_status();
        bit         eh = exp_show();
        n_cmp++;
        if (status !== es || show_status !== eh) begin
            n_bad++;
            $display("FAIL %s: status=%02h show=%0b expected status=%02h show=%0b",
                     tag, status, show_status, es, eh);
        end
        n_cmp++;
        if (status[4] !== 1'b0 || status[1] !== 1'b0 || status[0] !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: status=%02h expected bits 4,1,0 = 0", status);
        end
    endtask

    task automatic step(logic [2:0] op, bit rd, bit ain, bit bf, bit d7,
                        bit fl, bit rc, string tag);
        @(negedge clk);
        op_state = op; rd_stb = rd; addr_in_erase = ain; blk_failed = bf;
        pend_d7 = d7; fail_evt = fl; reset_cmd = rc;
        #2;
        check(tag);
        model_edge();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 1, "R12");   // reset_cmd outside error: no effect
        // program
        step(1, 1, 0, 0, 1, 0, 0, "R11");
        step(1, 1, 0, 0, 1, 0, 0, "R11");   // first read after start
        step(1, 0, 0, 0, 1, 0, 0, "R3");
        step(1, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 0, 0, "R3");
        step(7, 0, 0, 0, 0, 0, 0, "R12");
        // block erase window then erase
        step(2, 1, 1, 0, 0, 0, 0, "R6");
        step(2, 1, 0, 0, 0, 0, 0, "R7");
        step(2, 1, 1, 0, 0, 0, 0, "R7");
        step(3, 1, 0, 0, 0, 0, 0, "R6");
        step(3, 1, 1, 0, 0, 0, 0, "R7");
        step(4, 1, 0, 0, 0, 0, 0, "R6");
        // suspend
        step(4, 1, 1, 0, 0, 0, 0, "R2");
        step(4, 1, 1, 0, 0, 0, 0, "R4");
        step(4, 1, 0, 0, 0, 0, 0, "R9");
        step(1, 1, 1, 0, 1, 0, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 0, "R11");   // program from suspend, toggles cleared
        step(4, 0, 0, 0, 0, 0, 0, "R3");
        step(3, 0, 1, 0, 0, 0, 0, "R4");
        // erase failure
        step(3, 1, 1, 0, 0, 1, 0, "R6");
        step(0, 1, 1, 1, 0, 0, 0, "R5");
        step(0, 1, 1, 0, 0, 0, 0, "R8");
        step(2, 1, 1, 1, 0, 0, 0, "R8");
        step(4, 1, 0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        // program failure
        step(1, 0, 0, 0, 1, 0, 0, "R11");
        step(1, 1, 0, 0, 1, 1, 0, "R2");
        step(0, 1, 1, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 0, 0, 0, "R1");

        // constrained random
        begin
            logic [2:0] cur_op = 3'd0;
            for (int i = 0; i < 4000; i++) begin
                if (($urandom % 6) == 0) cur_op = 3'($urandom % 8);
                step(cur_op, ($urandom % 2) == 1, ($urandom % 2) == 1,
                     ($urandom % 2) == 1, ($urandom % 2) == 1,
                     ($urandom % 40) == 0, ($urandom % 12) == 0, st_tag());
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule